// File: doc/BRIEF.md
# Keyed Flash Command Front-End

This block sits between a 16-bit register bus and a flash array sequencer. Software writes a command word that holds a 7-bit opcode in bits 6:0 and an 8-bit key in bits 15:8. Bit 7 is reserved. The block acts on the word only when the key byte equals 0xA5. Each accepted opcode becomes one of three things: an operation request to the array, an update of internal protection state, or a refusal with an error flag.

Protection state is kept in sticky bits:
- one lock bit per address region;
- a boot-protection-disable bit, which exposes the lowest regions to erase and write;
- a chip-erase lock bit.

Results are reported through a four-bit flag register. Writing 1 to a flag bit clears it. Two separate registers set and clear the matching interrupt enables. A level interrupt combines the flags with their enables.

The array is modelled by a request/acknowledge pair. A request holds its opcode and address steady until the acknowledge arrives. While a request is outstanding the block reports itself not ready.

Top module: `flash_cmd_frontend`

## Requirements
- R1: A command write (offset 0x04) whose bits 15:8 differ from 0xA5 starts nothing. It sets the programming-error flag (flag bit 2) and does not set done (flag bit 0).
- R2: A correctly keyed command whose opcode is not one of 0x00, 0x01, 0x03, 0x04, 0x10, 0x11, 0x12, 0x15, 0x18, 0x19, 0x1A or 0x1B behaves the same way: programming-error flag set, nothing started, done not set.
- R3: Opcodes 0x00 (page erase), 0x01 (block erase), 0x03 (page write), 0x04 (quad-word write) and 0x15 (page-buffer clear) are array operations.
  - From the clock edge that takes the write, op_req_o rises, op_code_o carries the opcode and op_addr_o carries the address register (offset 0x14).
  - These outputs hold until op_ack_i is sampled high.
  - At that edge op_req_o falls and the done flag is set.
  - Status bit 0 (ready) is low while the request is outstanding.
- R4: A command written while not ready is dropped. It changes no flag, no protection bit and no outstanding request.
- R5: Opcode 0x11 locks, and 0x12 unlocks, the region holding the address register, where region index = address >> REGION_SHIFT. Either opcode sets done. An erase or write (0x00, 0x01, 0x03, 0x04) whose address lies in a locked region is refused: no request, and the lock-error flag (bit 3) and done are set. Other regions are unaffected.
- R6: Regions below BOOT_REGIONS are protected in the same way as locked regions while status bit 1 is 0. Opcode 0x1A sets status bit 1 and 0x1B clears it. Both set done.
- R7: Opcode 0x18 sets, and 0x19 clears, status bit 2 (chip-erase lock). Both set done.
- R8: An erase, write, lock or unlock whose region index is NUM_REGIONS or more is refused. It sets the address-error flag (bit 1) and done, starts no request and changes no lock.
- R9: Writing offset 0x10 clears each flag bit written with 1. Writing offset 0x0E sets, and offset 0x0C clears, each enable bit written with 1; bits written with 0 are untouched. Offsets 0x0C and 0x0E both read back the enables.
- R10: irq_o is high exactly when some flag bit and its enable bit are both 1.
- R11: Opcode 0x10 (soft reset) does all of the following at once:
  - clears every region lock, the boot-protection-disable bit, the chip-erase lock and all interrupt enables;
  - sets done.
- R12: After reset the flags, enables, locks and status bits 2:1 are 0, status bit 0 is 1, op_req_o is 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i (combinational) |
| op_req_o | output | 1 | Array operation request |
| op_code_o | output | 7 | Opcode of the outstanding request |
| op_addr_o | output | ADDR_W | Address of the outstanding request |
| op_ack_i | input | 1 | Array completion acknowledge |
| irq_o | output | 1 | Interrupt |

## Verification
The hardest situation to reach is a command that arrives while an array request is still outstanding. It must change nothing, so it cannot be confirmed by watching a single output.

To create it, the bench withholds op_ack_i after launching an erase. It then writes both a lock command and a badly keyed command into the busy window.

Afterwards it reads the flags, checks that the request's opcode stayed put, and releases the acknowledge. Finally it issues a page write to the same region: if the dropped lock had taken effect, that write would now be refused with a lock error.

Boot-region protection is exercised the same way. The protection-disable toggle is bracketed with erases that must be refused before the toggle, accepted while it is set, and refused again after it is cleared.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam logic [7:0] CMD_KEY = 8'hA5;

  localparam logic [7:0] OFS_CMD     = 8'h04;
  localparam logic [7:0] OFS_IEN_CLR = 8'h0C;
  localparam logic [7:0] OFS_IEN_SET = 8'h0E;
  localparam logic [7:0] OFS_FLAG    = 8'h10;
  localparam logic [7:0] OFS_STAT    = 8'h12;
  localparam logic [7:0] OFS_ADDR    = 8'h14;

  localparam int NUM_FLAGS = 4;
  localparam int FLG_DONE  = 0;
  localparam int FLG_ADDR  = 1;
  localparam int FLG_PROG  = 2;
  localparam int FLG_LOCK  = 3;

  typedef enum logic [6:0] {
    OP_ERASE_PAGE  = 7'h00,
    OP_ERASE_BLOCK = 7'h01,
    OP_WRITE_PAGE  = 7'h03,
    OP_WRITE_QUAD  = 7'h04,
    OP_SOFT_RST    = 7'h10,
    OP_LOCK        = 7'h11,
    OP_UNLOCK      = 7'h12,
    OP_BUF_CLR     = 7'h15,
    OP_CE_LOCK     = 7'h18,
    OP_CE_UNLOCK   = 7'h19,
    OP_BP_OFF      = 7'h1A,
    OP_BP_ON       = 7'h1B
  } opcode_e;

  typedef struct packed {
    logic valid;
    logic array_op;
    logic modifies;
    logic needs_addr;
    logic do_lock;
    logic do_unlock;
    logic soft_rst;
    logic bp_dis_set;
    logic bp_dis_clr;
    logic ce_set;
    logic ce_clr;
  } cmd_dec_t;

endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
  import flash_cmd_pkg::*;
(
  input  logic [15:0] word_i,
  output logic        key_ok_o,
  output cmd_dec_t    dec_o
);

  cmd_dec_t d;

  always_comb begin
    d = '0;
    unique case (word_i[6:0])
      OP_ERASE_PAGE, OP_ERASE_BLOCK, OP_WRITE_PAGE, OP_WRITE_QUAD: begin
        d.valid = 1'b1; d.array_op = 1'b1; d.modifies = 1'b1; d.needs_addr = 1'b1;
      end
      OP_BUF_CLR:   begin d.valid = 1'b1; d.array_op = 1'b1; end
      OP_LOCK:      begin d.valid = 1'b1; d.do_lock = 1'b1; d.needs_addr = 1'b1; end
      OP_UNLOCK:    begin d.valid = 1'b1; d.do_unlock = 1'b1; d.needs_addr = 1'b1; end
      OP_SOFT_RST:  begin d.valid = 1'b1; d.soft_rst = 1'b1; end
      OP_BP_OFF:    begin d.valid = 1'b1; d.bp_dis_set = 1'b1; end
      OP_BP_ON:     begin d.valid = 1'b1; d.bp_dis_clr = 1'b1; end
      OP_CE_LOCK:   begin d.valid = 1'b1; d.ce_set = 1'b1; end
      OP_CE_UNLOCK: begin d.valid = 1'b1; d.ce_clr = 1'b1; end
      default:      d = '0;
    endcase
  end

  assign key_ok_o = (word_i[15:8] == CMD_KEY);

  // A bad key masks every decoded action.
  assign dec_o = key_ok_o ? d : '0;

endmodule

// File: rtl/flash_region_locks.sv
module flash_region_locks #(
  parameter int NUM_REGIONS = 32,
  parameter int IDX_W       = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic             clr_all_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             locked_o
);

  logic [NUM_REGIONS-1:0] lock_q;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic hit;
    assign hit = (idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               lock_q[i] <= 1'b0;
      else if (clr_all_i)        lock_q[i] <= 1'b0;
      else if (hit && set_i)     lock_q[i] <= 1'b1;
      else if (hit && clr_i)     lock_q[i] <= 1'b0;
    end

    // R5
    lock_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i && hit && !clr_all_i |=> lock_q[i]);

    // R11
    lock_wipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_all_i |=> !lock_q[i]);
  end

  always_comb begin
    locked_o = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (idx_i == IDX_W'(i)) locked_o = lock_q[i];
  end

endmodule

// File: rtl/flash_irq_regs.sv
module flash_irq_regs #(
  parameter int NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_set_we_i,
  input  logic          en_clr_we_i,
  input  logic          en_clr_all_i,
  input  logic          flag_clr_we_i,
  input  logic [NF-1:0] wdata_i,
  input  logic [NF-1:0] flag_set_i,
  output logic [NF-1:0] en_o,
  output logic [NF-1:0] flag_o,
  output logic          irq_o
);

  logic [NF-1:0] en_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (en_clr_all_i) begin
      en_q <= '0;
    end else if (en_set_we_i) begin
      en_q <= en_q | wdata_i;
    end else if (en_clr_we_i) begin
      en_q <= en_q & ~wdata_i;
    end
  end

  // A completing event wins over a simultaneous clear.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~(flag_clr_we_i ? wdata_i : '0)) | flag_set_i;
  end

  assign en_o   = en_q;
  assign flag_o = flag_q;
  assign irq_o  = |(flag_q & en_q);

  // R9
  flag_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_we_i && wdata_i[0] && !flag_set_i[0] |=> !flag_o[0]);

  // R9
  en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_we_i && !en_clr_all_i |=> ((en_o & $past(wdata_i)) == $past(wdata_i)));

  // R10
  irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_all_i |=> !irq_o);

endmodule

// File: rtl/flash_cmd_frontend.sv
module flash_cmd_frontend
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int REGION_SHIFT = 10,
  parameter int NUM_REGIONS  = 32,
  parameter int BOOT_REGIONS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [15:0]       reg_wdata_i,
  output logic [15:0]       reg_rdata_o,
  output logic              op_req_o,
  output logic [6:0]        op_code_o,
  output logic [ADDR_W-1:0] op_addr_o,
  input  logic              op_ack_i,
  output logic              irq_o
);

  localparam int IDX_W = ADDR_W - REGION_SHIFT;
  localparam logic [IDX_W:0] NREG  = (IDX_W+1)'(NUM_REGIONS);
  localparam logic [IDX_W:0] NBOOT = (IDX_W+1)'(BOOT_REGIONS);

  logic              busy_q, bpdis_q, celock_q;
  logic [6:0]        code_q;
  logic [ADDR_W-1:0] addr_q, op_addr_q;

  logic            cmd_we, take, accepted, addr_bad, boot_hit, locked;
  logic            addr_fail, lock_fail, launch, internal_done;
  logic            key_ok;
  cmd_dec_t        dec;
  logic [IDX_W-1:0] idx;
  logic [NUM_FLAGS-1:0] flag_set, en, flags;

  flash_cmd_decode u_dec (
    .word_i   (reg_wdata_i),
    .key_ok_o (key_ok),
    .dec_o    (dec)
  );

  assign cmd_we   = reg_we_i && (reg_addr_i == OFS_CMD);
  assign take     = cmd_we && !busy_q;
  assign accepted = take && dec.valid;

  assign idx      = addr_q[ADDR_W-1:REGION_SHIFT];
  assign addr_bad = {1'b0, idx} >= NREG;
  assign boot_hit = ({1'b0, idx} < NBOOT) && !bpdis_q;

  assign addr_fail     = accepted && dec.needs_addr && addr_bad;
  assign lock_fail     = accepted && dec.modifies && !addr_bad && (locked || boot_hit);
  assign launch        = accepted && dec.array_op && !addr_fail && !lock_fail;
  assign internal_done = accepted && !dec.array_op && !addr_fail;

  flash_region_locks #(
    .NUM_REGIONS (NUM_REGIONS),
    .IDX_W       (IDX_W)
  ) u_locks (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (accepted && dec.do_lock && !addr_bad),
    .clr_i     (accepted && dec.do_unlock && !addr_bad),
    .clr_all_i (accepted && dec.soft_rst),
    .idx_i     (idx),
    .locked_o  (locked)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_DONE] = (busy_q && op_ack_i) || addr_fail || lock_fail || internal_done;
    flag_set[FLG_ADDR] = addr_fail;
    flag_set[FLG_PROG] = take && !dec.valid;
    flag_set[FLG_LOCK] = lock_fail;
  end

  flash_irq_regs #(.NF(NUM_FLAGS)) u_irq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_set_we_i   (reg_we_i && reg_addr_i == OFS_IEN_SET),
    .en_clr_we_i   (reg_we_i && reg_addr_i == OFS_IEN_CLR),
    .en_clr_all_i  (accepted && dec.soft_rst),
    .flag_clr_we_i (reg_we_i && reg_addr_i == OFS_FLAG),
    .wdata_i       (reg_wdata_i[NUM_FLAGS-1:0]),
    .flag_set_i    (flag_set),
    .en_o          (en),
    .flag_o        (flags),
    .irq_o         (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      code_q    <= '0;
      op_addr_q <= '0;
    end else if (launch) begin
      busy_q    <= 1'b1;
      code_q    <= reg_wdata_i[6:0];
      op_addr_q <= addr_q;
    end else if (busy_q && op_ack_i) begin
      busy_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (reg_we_i && reg_addr_i == OFS_ADDR) begin
      addr_q <= reg_wdata_i[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bpdis_q  <= 1'b0;
      celock_q <= 1'b0;
    end else if (accepted) begin
      if (dec.soft_rst || dec.bp_dis_clr) bpdis_q <= 1'b0;
      else if (dec.bp_dis_set)            bpdis_q <= 1'b1;
      if (dec.soft_rst || dec.ce_clr)     celock_q <= 1'b0;
      else if (dec.ce_set)                celock_q <= 1'b1;
    end
  end

  assign op_req_o  = busy_q;
  assign op_code_o = code_q;
  assign op_addr_o = op_addr_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_IEN_CLR, OFS_IEN_SET: reg_rdata_o[NUM_FLAGS-1:0] = en;
      OFS_FLAG:                 reg_rdata_o[NUM_FLAGS-1:0] = flags;
      OFS_STAT:                 reg_rdata_o[2:0] = {celock_q, bpdis_q, !busy_q};
      OFS_ADDR:                 reg_rdata_o[ADDR_W-1:0] = addr_q;
      default:                  reg_rdata_o = '0;
    endcase
  end

  // R3
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o && !op_ack_i |=> op_req_o && $stable(op_code_o) && $stable(op_addr_o));

  // R4
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_req_o && !op_ack_i |=> $stable(bpdis_q) && $stable(celock_q));

  // R1
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we && !key_ok && !op_req_o |=> flags[FLG_PROG] && !op_req_o);

  // R6
  bp_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we |=> $stable(bpdis_q));

  // R8
  addr_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_fail |=> flags[FLG_ADDR] && flags[FLG_DONE] && !op_req_o);

endmodule

// File: tb/tb_flash_cmd_frontend.sv
`timescale 1ns/1ps
module tb_flash_cmd_frontend;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = 8'h00;
  logic [15:0] reg_wdata_i = 16'h0;
  logic [15:0] reg_rdata_o;
  logic        op_req_o;
  logic [6:0]  op_code_o;
  logic [15:0] op_addr_o;
  logic        op_ack_i = 1'b0;
  logic        irq_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  flash_cmd_frontend dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .op_req_o    (op_req_o),
    .op_code_o   (op_code_o),
    .op_addr_o   (op_addr_o),
    .op_ack_i    (op_ack_i),
    .irq_o       (irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic ack();
    @(negedge clk_i); op_ack_i = 1'b1;
    @(negedge clk_i); op_ack_i = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [15:0] e);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, e);
  endtask

  task automatic clr_flags();
    wr(8'h10, 16'h000F);
  endtask

  task automatic t_reset();
    expect_reg("R12 flags", 8'h10, 16'h0);
    expect_reg("R12 enables", 8'h0E, 16'h0);
    expect_reg("R12 status", 8'h12, 16'h0001);
    chk("R12 op_req", op_req_o, 0);
    chk("R12 irq", irq_o, 0);
  endtask

  task automatic t_bad_key();
    wr(8'h14, 16'h0800);
    wr(8'h04, 16'h5A03);
    chk("R1 no request", op_req_o, 0);
    expect_reg("R1 prog flag only", 8'h10, 16'h0004);
    clr_flags();
    expect_reg("R9 flags cleared", 8'h10, 16'h0);
  endtask

  task automatic t_unknown();
    wr(8'h04, 16'hA502);
    chk("R2 no request", op_req_o, 0);
    expect_reg("R2 prog flag only", 8'h10, 16'h0004);
    clr_flags();
  endtask

  task automatic t_array();
    wr(8'h14, 16'h0800);
    wr(8'h04, 16'hA503);
    chk("R3 req", op_req_o, 1);
    chk("R3 code", op_code_o, 7'h03);
    chk("R3 addr", op_addr_o, 16'h0800);
    expect_reg("R3 not ready", 8'h12, 16'h0000);
    expect_reg("R3 no done yet", 8'h10, 16'h0);
    repeat (3) @(negedge clk_i);
    chk("R3 req held", op_req_o, 1);
    ack();
    chk("R3 req dropped", op_req_o, 0);
    expect_reg("R3 done", 8'h10, 16'h0001);
    expect_reg("R3 ready", 8'h12, 16'h0001);
    clr_flags();
    wr(8'h04, 16'hA515);
    chk("R3 buffer clear req", op_req_o, 1);
    chk("R3 buffer clear code", op_code_o, 7'h15);
    ack();
    expect_reg("R3 buffer clear done", 8'h10, 16'h0001);
    clr_flags();
  endtask

  task automatic t_busy_drop();
    wr(8'h14, 16'h0800);
    wr(8'h04, 16'hA500);
    chk("R4 erase req", op_req_o, 1);
    wr(8'h04, 16'hA511);
    wr(8'h04, 16'h0003);
    wr(8'h04, 16'hA518);
    chk("R4 code kept", op_code_o, 7'h00);
    expect_reg("R4 flags untouched", 8'h10, 16'h0);
    expect_reg("R4 status untouched", 8'h12, 16'h0000);
    ack();
    clr_flags();
    wr(8'h04, 16'hA503);
    chk("R4 region not locked", op_req_o, 1);
    ack();
    clr_flags();
  endtask

  task automatic t_lock();
    wr(8'h14, 16'h0C00);
    wr(8'h04, 16'hA511);
    expect_reg("R5 lock done", 8'h10, 16'h0001);
    clr_flags();
    wr(8'h04, 16'hA500);
    chk("R5 refused", op_req_o, 0);
    expect_reg("R5 lock error", 8'h10, 16'h0009);
    clr_flags();
    wr(8'h14, 16'h1000);
    wr(8'h04, 16'hA504);
    chk("R5 neighbour free", op_req_o, 1);
    ack();
    clr_flags();
    wr(8'h14, 16'h0FFE);
    wr(8'h04, 16'hA512);
    expect_reg("R5 unlock done", 8'h10, 16'h0001);
    clr_flags();
    wr(8'h04, 16'hA501);
    chk("R5 unlocked accepts", op_req_o, 1);
    ack();
    clr_flags();
  endtask

  task automatic t_boot();
    wr(8'h14, 16'h0400);
    wr(8'h04, 16'hA500);
    chk("R6 boot refused", op_req_o, 0);
    expect_reg("R6 boot lock error", 8'h10, 16'h0009);
    clr_flags();
    wr(8'h04, 16'hA51A);
    expect_reg("R6 bpdis set", 8'h12, 16'h0003);
    wr(8'h04, 16'hA500);
    chk("R6 boot open", op_req_o, 1);
    ack();
    clr_flags();
    wr(8'h04, 16'hA51B);
    expect_reg("R6 bpdis clear", 8'h12, 16'h0001);
    wr(8'h04, 16'hA503);
    chk("R6 boot refused again", op_req_o, 0);
    expect_reg("R6 lock error again", 8'h10, 16'h0009);
    clr_flags();
  endtask

  task automatic t_ce();
    wr(8'h04, 16'hA518);
    expect_reg("R7 ce lock set", 8'h12, 16'h0005);
    expect_reg("R7 done", 8'h10, 16'h0001);
    wr(8'h04, 16'hA519);
    expect_reg("R7 ce lock clear", 8'h12, 16'h0001);
    clr_flags();
  endtask

  task automatic t_addr();
    wr(8'h14, 16'h8000);
    wr(8'h04, 16'hA500);
    chk("R8 no request", op_req_o, 0);
    expect_reg("R8 addr error", 8'h10, 16'h0003);
    clr_flags();
    wr(8'h04, 16'hA511);
    expect_reg("R8 lock addr error", 8'h10, 16'h0003);
    clr_flags();
  endtask

  task automatic t_irq();
    wr(8'h04, 16'h1103);
    chk("R10 no enable no irq", irq_o, 0);
    wr(8'h0E, 16'h0004);
    chk("R10 irq on", irq_o, 1);
    expect_reg("R9 enable read", 8'h0C, 16'h0004);
    wr(8'h0E, 16'h0000);
    expect_reg("R9 zero write no effect", 8'h0E, 16'h0004);
    wr(8'h0C, 16'h0004);
    chk("R10 irq off by enable clear", irq_o, 0);
    expect_reg("R9 flag kept", 8'h10, 16'h0004);
    wr(8'h0E, 16'h000F);
    chk("R10 irq on again", irq_o, 1);
    wr(8'h10, 16'h0001);
    expect_reg("R9 w1c other bit only", 8'h10, 16'h0004);
    wr(8'h10, 16'h0004);
    chk("R10 irq off by flag clear", irq_o, 0);
    wr(8'h0C, 16'h000F);
  endtask

  task automatic t_softrst();
    wr(8'h14, 16'h0C00);
    wr(8'h04, 16'hA511);
    wr(8'h04, 16'hA51A);
    wr(8'h04, 16'hA518);
    wr(8'h0E, 16'h000E);
    clr_flags();
    wr(8'h04, 16'hA510);
    expect_reg("R11 status", 8'h12, 16'h0001);
    expect_reg("R11 enables", 8'h0E, 16'h0000);
    expect_reg("R11 done", 8'h10, 16'h0001);
    chk("R11 irq", irq_o, 0);
    clr_flags();
    wr(8'h04, 16'hA500);
    chk("R11 lock wiped", op_req_o, 1);
    ack();
    clr_flags();
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_bad_key();
    t_unknown();
    t_array();
    t_busy_drop();
    t_lock();
    t_boot();
    t_ce();
    t_addr();
    t_irq();
    t_softrst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule